// File: doc/BRIEF.md
# Two-Stage GPIO Pin Routing Crossbar

This block sits between a set of shared package pads and a bank of internal peripheral signals. It routes signals in two stages. The first stage is one global group selector that decides, for every shared pad at the same moment, which function set the pad carries. Group 0 is the boot group: each pad is tied straight to a fixed peripheral output, and no GPIO line reaches any pad. Groups 1 to 6 connect each pad to an internal GPIO line. The pad-to-line pairing rotates with the group number, so a given GPIO line lands on a different pad in each group.

The second stage is a crossbar whose routing is chosen at the destination. Each GPIO output and each GPIO output enable has its own selector. Each peripheral input also has its own selector, which picks a GPIO input line. Every selector can also pick a constant 0 or a constant 1.

A word-wide register bus carries the configuration. Through the same bus, software reads the synchronised level of each GPIO line and services per-line interrupts with sticky pending bits. A routing-reset command turns off every GPIO output enable except on the lines named in a keep mask.

Top module: `pinroute_xbar`

## Requirements
- R1: The group register (address 0x00, bits [2:0]) accepts the values 0 to 6. A write of 7 or more leaves the stored group unchanged. Reading address 0x00 returns the current group.
- R2: After reset the group is 0. In group 0, pad p outputs `per_out[p]` with enable `per_oe[p]`, and every GPIO input line reads 0 whatever the pads carry.
- R3: In group g (1 to 6), pad p is driven by the output and output enable of GPIO line (p+g) mod N. GPIO line n takes its input from pad (n-g) mod N, where N is the number of GPIO lines and N is also the number of pads.
- R4: Line n has a configuration register at address 0x40+n. Bits [3:0] hold the output selector, bits [11:8] hold the output-enable selector, and bits [17:16] hold the interrupt mode. In both selectors, code 0 means constant 0, code 1 means constant 1, and code 2+k means peripheral output k. The output selector takes `per_out[k]` and the enable selector takes `per_oe[k]`.
- R5: Peripheral input k has a selector at address 0x80+k, bits [3:0]. Code 0 means constant 0, code 1 means constant 1, and code 2+n means GPIO input line n. This path is combinational and has no synchroniser.
- R6: Any selector code above the highest implemented source routes constant 0.
- R7: At reset, line 0 has output and enable codes of 2 (debug data out, read value 0x202). Peripheral inputs 0 to 3 (debug clock, data in, mode select, reset) hold codes 3 to 6, so they take GPIO lines 1 to 4. Every other selector holds 0.
- R8: Reading address 0x04 returns the GPIO input levels after a two-flop synchroniser. A pad change therefore appears after the second rising clock edge and not after the first.
- R9: Each line has an interrupt mode: 0 for a rising edge, 1 for a falling edge, 2 for a high level and 3 for a low level. The mode acts on the synchronised input. Pending bits at address 0x18 are sticky and are cleared by writing 1 to them. While a level condition holds, its pending bit stays set even if a clear is written.
- R10: `irq` is high exactly when some pending bit is set and its enable bit at address 0x10 is also set.
- R11: Writing 1 to bit 0 of address 0x01 sets the output-enable selector of every line to 0. Lines whose bit is set in the keep mask at address 0x20 are left unchanged, as are all output selectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | NUM_GPIO | Levels arriving from the shared pads |
| pad_out | output | NUM_GPIO | Values driven onto the shared pads |
| pad_oe | output | NUM_GPIO | Output enables of the shared pads |
| per_out | input | NUM_PER_OUT | Peripheral output signals |
| per_oe | input | NUM_PER_OUT | Peripheral output enables |
| per_in | output | NUM_PER_IN | Peripheral input signals |
| irq | output | 1 | Interrupt request |

## Verification
The pad stage is tested in group 0 and in two rotated groups, using asymmetric pad patterns such as 0x96, so that an off-by-one or reversed rotation gives a different vector. The crossbar is loaded with a different selector code on every line, covering constants, mid-range sources and codes beyond the range. This separates constant handling, index offset and out-of-range masking, and changing `per_out` afterwards shows that the routing is live rather than latched. The input timing is tested by sampling the readback after one clock edge and again after two. Each interrupt mode is driven with the edge or level that should fire it and with the opposite condition. Clearing while a level is held shows whether the clear wins over a live condition.

// File: rtl/prx_pkg.sv
package prx_pkg;
  typedef enum logic [1:0] {
    IRQ_RISE = 2'd0,
    IRQ_FALL = 2'd1,
    IRQ_HIGH = 2'd2,
    IRQ_LOW  = 2'd3
  } irq_mode_e;

  localparam int NUM_GROUPS = 7;
  localparam int GRP_W      = 3;
  localparam int OE_LSB     = 8;
  localparam int MODE_LSB   = 16;

  localparam logic [7:0] A_GRP  = 8'h00;
  localparam logic [7:0] A_CMD  = 8'h01;
  localparam logic [7:0] A_DIN  = 8'h04;
  localparam logic [7:0] A_IEN  = 8'h10;
  localparam logic [7:0] A_PEND = 8'h18;
  localparam logic [7:0] A_KEEP = 8'h20;
endpackage

// File: rtl/prx_pad_group.sv
module prx_pad_group
  import prx_pkg::*;
#(
  parameter int NUM_PADS    = 8,
  parameter int NUM_PER_OUT = 8
) (
  input  logic [GRP_W-1:0]       grp,
  input  logic [NUM_PER_OUT-1:0] per_out,
  input  logic [NUM_PER_OUT-1:0] per_oe,
  input  logic [NUM_PADS-1:0]    gpio_out,
  input  logic [NUM_PADS-1:0]    gpio_oe,
  input  logic [NUM_PADS-1:0]    pad_in,
  output logic [NUM_PADS-1:0]    pad_out,
  output logic [NUM_PADS-1:0]    pad_oe,
  output logic [NUM_PADS-1:0]    gpio_in
);
  localparam int SLOTS = 1 << GRP_W;

  logic [NUM_PADS-1:0] out_g [SLOTS];
  logic [NUM_PADS-1:0] oe_g  [SLOTS];
  logic [NUM_PADS-1:0] in_g  [SLOTS];

  // One routing vector per group code; unused codes mirror the boot group.
  for (genvar g = 0; g < SLOTS; g++) begin : g_grp
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      if (g == 0 || g >= NUM_GROUPS) begin : g_fixed
        assign out_g[g][p] = per_out[p % NUM_PER_OUT];
        assign oe_g[g][p]  = per_oe[p % NUM_PER_OUT];
        assign in_g[g][p]  = 1'b0;
      end else begin : g_rot
        assign out_g[g][p] = gpio_out[(p + g) % NUM_PADS];
        assign oe_g[g][p]  = gpio_oe[(p + g) % NUM_PADS];
        assign in_g[g][p]  = pad_in[(p + NUM_PADS - (g % NUM_PADS)) % NUM_PADS];
      end
    end
  end

  assign pad_out = out_g[grp];
  assign pad_oe  = oe_g[grp];
  assign gpio_in = in_g[grp];
endmodule

// File: rtl/prx_crossbar.sv
module prx_crossbar #(
  parameter int NUM_GPIO    = 8,
  parameter int NUM_PER_OUT = 8,
  parameter int NUM_PER_IN  = 8,
  parameter int OSW         = 4,
  parameter int ISW         = 4
) (
  input  logic [OSW-1:0]         osel [NUM_GPIO],
  input  logic [OSW-1:0]         esel [NUM_GPIO],
  input  logic [ISW-1:0]         isel [NUM_PER_IN],
  input  logic [NUM_PER_OUT-1:0] per_out,
  input  logic [NUM_PER_OUT-1:0] per_oe,
  input  logic [NUM_GPIO-1:0]    gpio_in,
  output logic [NUM_GPIO-1:0]    gpio_out,
  output logic [NUM_GPIO-1:0]    gpio_oe,
  output logic [NUM_PER_IN-1:0]  per_in
);
  localparam int OSRC = 1 << OSW;
  localparam int ISRC = 1 << ISW;

  // Source vectors: code 0 -> 0, code 1 -> 1, code 2+k -> source k, above -> 0.
  logic [OSRC-1:0] out_src;
  logic [OSRC-1:0] oe_src;
  logic [ISRC-1:0] in_src;

  assign out_src = OSRC'({per_out, 2'b10});
  assign oe_src  = OSRC'({per_oe, 2'b10});
  assign in_src  = ISRC'({gpio_in, 2'b10});

  for (genvar n = 0; n < NUM_GPIO; n++) begin : g_line
    assign gpio_out[n] = out_src[osel[n]];
    assign gpio_oe[n]  = oe_src[esel[n]];
  end

  for (genvar k = 0; k < NUM_PER_IN; k++) begin : g_pin
    assign per_in[k] = in_src[isel[k]];
  end
endmodule

// File: rtl/prx_irq.sv
module prx_irq
  import prx_pkg::*;
#(
  parameter int NUM_GPIO = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_GPIO-1:0] gpio_in,
  input  logic [1:0]          mode [NUM_GPIO],
  input  logic [NUM_GPIO-1:0] en,
  input  logic                clr_stb,
  input  logic [NUM_GPIO-1:0] clr_mask,
  output logic [NUM_GPIO-1:0] din,
  output logic [NUM_GPIO-1:0] pend,
  output logic                irq
);
  logic [NUM_GPIO-1:0] s1_q, s2_q, s3_q, pend_q;
  logic [NUM_GPIO-1:0] hit, pend_d;

  always_comb begin
    for (int n = 0; n < NUM_GPIO; n++) begin
      case (irq_mode_e'(mode[n]))
        IRQ_RISE: hit[n] = s2_q[n] & ~s3_q[n];
        IRQ_FALL: hit[n] = ~s2_q[n] & s3_q[n];
        IRQ_HIGH: hit[n] = s2_q[n];
        default:  hit[n] = ~s2_q[n];
      endcase
    end
    pend_d = (pend_q & ~(clr_stb ? clr_mask : '0)) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      s3_q   <= '0;
      pend_q <= '0;
    end else begin
      s1_q   <= gpio_in;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      pend_q <= pend_d;
    end
  end

  assign din  = s2_q;
  assign pend = pend_q;
  assign irq  = |(pend_q & en);

  // R10: no enabled line, no request
  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);

  for (genvar n = 0; n < NUM_GPIO; n++) begin : g_chk
    // R9: a pending bit only drops through an explicit clear
    assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[n] && !(clr_stb && clr_mask[n])) |=> pend_q[n]);
  end
endmodule

// File: rtl/pinroute_xbar.sv
module pinroute_xbar
  import prx_pkg::*;
#(
  parameter int NUM_GPIO    = 8,
  parameter int NUM_PER_OUT = 8,
  parameter int NUM_PER_IN  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_wr,
  input  logic [7:0]             bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NUM_GPIO-1:0]    pad_in,
  output logic [NUM_GPIO-1:0]    pad_out,
  output logic [NUM_GPIO-1:0]    pad_oe,
  input  logic [NUM_PER_OUT-1:0] per_out,
  input  logic [NUM_PER_OUT-1:0] per_oe,
  output logic [NUM_PER_IN-1:0]  per_in,
  output logic                   irq
);
  localparam int OSW = $clog2(NUM_PER_OUT + 2);
  localparam int ISW = $clog2(NUM_GPIO + 2);
  localparam int LW  = $clog2(NUM_GPIO);
  localparam int PW  = $clog2(NUM_PER_IN);

  // Asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [GRP_W-1:0]    grp_q, grp_d;
  logic [NUM_GPIO-1:0] keep_q, keep_d, ien_q, ien_d;
  logic [OSW-1:0]      osel_q [NUM_GPIO];
  logic [OSW-1:0]      osel_d [NUM_GPIO];
  logic [OSW-1:0]      esel_q [NUM_GPIO];
  logic [OSW-1:0]      esel_d [NUM_GPIO];
  logic [1:0]          mode_q [NUM_GPIO];
  logic [1:0]          mode_d [NUM_GPIO];
  logic [ISW-1:0]      isel_q [NUM_PER_IN];
  logic [ISW-1:0]      isel_d [NUM_PER_IN];

  logic                line_hit, pin_hit, clr_stb;
  logic [LW-1:0]       lidx;
  logic [PW-1:0]       pidx;
  logic [NUM_GPIO-1:0] clr_mask;
  logic [NUM_GPIO-1:0] gpio_out_w, gpio_oe_w, gpio_in_w, din_w, pend_w;

  assign line_hit = (bus_addr[7:6] == 2'b01) && (int'(bus_addr[5:0]) < NUM_GPIO);
  assign pin_hit  = bus_addr[7] && (int'(bus_addr[6:0]) < NUM_PER_IN);
  assign lidx     = bus_addr[LW-1:0];
  assign pidx     = bus_addr[PW-1:0];
  assign clr_stb  = bus_wr;

  // Next-state logic for the configuration registers
  always_comb begin
    grp_d  = grp_q;
    keep_d = keep_q;
    ien_d  = ien_q;
    osel_d = osel_q;
    esel_d = esel_q;
    mode_d = mode_q;
    isel_d = isel_q;
    for (int i = 0; i < NUM_GPIO; i++) begin
      clr_mask[i] = (bus_addr == A_PEND + 8'(i / 32)) && bus_wdata[i % 32];
    end
    if (bus_wr) begin
      if (bus_addr == A_GRP && bus_wdata < 32'(NUM_GROUPS)) begin
        grp_d = bus_wdata[GRP_W-1:0];
      end
      if (bus_addr == A_CMD && bus_wdata[0]) begin
        for (int n = 0; n < NUM_GPIO; n++) begin
          if (!keep_q[n]) esel_d[n] = '0;
        end
      end
      for (int i = 0; i < NUM_GPIO; i++) begin
        if (bus_addr == A_IEN + 8'(i / 32))  ien_d[i]  = bus_wdata[i % 32];
        if (bus_addr == A_KEEP + 8'(i / 32)) keep_d[i] = bus_wdata[i % 32];
      end
      if (line_hit) begin
        osel_d[lidx] = bus_wdata[OSW-1:0];
        esel_d[lidx] = bus_wdata[OE_LSB +: OSW];
        mode_d[lidx] = bus_wdata[MODE_LSB +: 2];
      end
      if (pin_hit) begin
        isel_d[pidx] = bus_wdata[ISW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      grp_q  <= '0;
      keep_q <= '0;
      ien_q  <= '0;
      for (int n = 0; n < NUM_GPIO; n++) begin
        osel_q[n] <= (n == 0) ? OSW'(2) : '0;
        esel_q[n] <= (n == 0) ? OSW'(2) : '0;
        mode_q[n] <= '0;
      end
      for (int k = 0; k < NUM_PER_IN; k++) begin
        isel_q[k] <= (k < 4) ? ISW'(k + 3) : '0;
      end
    end else begin
      grp_q  <= grp_d;
      keep_q <= keep_d;
      ien_q  <= ien_d;
      osel_q <= osel_d;
      esel_q <= esel_d;
      mode_q <= mode_d;
      isel_q <= isel_d;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_GRP) bus_rdata = 32'(grp_q);
    for (int i = 0; i < NUM_GPIO; i++) begin
      if (bus_addr == A_DIN + 8'(i / 32))  bus_rdata[i % 32] = din_w[i];
      if (bus_addr == A_IEN + 8'(i / 32))  bus_rdata[i % 32] = ien_q[i];
      if (bus_addr == A_PEND + 8'(i / 32)) bus_rdata[i % 32] = pend_w[i];
      if (bus_addr == A_KEEP + 8'(i / 32)) bus_rdata[i % 32] = keep_q[i];
    end
    if (line_hit) begin
      bus_rdata[OSW-1:0]          = osel_q[lidx];
      bus_rdata[OE_LSB +: OSW]    = esel_q[lidx];
      bus_rdata[MODE_LSB +: 2]    = mode_q[lidx];
    end
    if (pin_hit) bus_rdata[ISW-1:0] = isel_q[pidx];
  end

  prx_pad_group #(.NUM_PADS(NUM_GPIO), .NUM_PER_OUT(NUM_PER_OUT)) u_pads (
    .grp(grp_q), .per_out(per_out), .per_oe(per_oe),
    .gpio_out(gpio_out_w), .gpio_oe(gpio_oe_w), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .gpio_in(gpio_in_w)
  );

  prx_crossbar #(.NUM_GPIO(NUM_GPIO), .NUM_PER_OUT(NUM_PER_OUT), .NUM_PER_IN(NUM_PER_IN),
                 .OSW(OSW), .ISW(ISW)) u_xbar (
    .osel(osel_q), .esel(esel_q), .isel(isel_q),
    .per_out(per_out), .per_oe(per_oe), .gpio_in(gpio_in_w),
    .gpio_out(gpio_out_w), .gpio_oe(gpio_oe_w), .per_in(per_in)
  );

  prx_irq #(.NUM_GPIO(NUM_GPIO)) u_irq (
    .clk(clk), .rst_n(rst_int_n), .gpio_in(gpio_in_w), .mode(mode_q),
    .en(ien_q), .clr_stb(clr_stb), .clr_mask(clr_mask),
    .din(din_w), .pend(pend_w), .irq(irq)
  );

  // R1: stored group never leaves the legal range
  assert_grp_range_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    grp_q < GRP_W'(NUM_GROUPS));

  // R1: an illegal group write is dropped
  assert_bad_grp_ignored_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == A_GRP && bus_wdata >= 32'(NUM_GROUPS)) |=> $stable(grp_q));

  // R2: the boot group isolates every GPIO line from the pads
  assert_grp0_isolated_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (grp_q == '0) |-> (gpio_in_w == '0));

  for (genvar n = 0; n < NUM_GPIO; n++) begin : g_rr_chk
    // R11: routing reset turns off unkept enables
    assert_route_reset_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
      (bus_wr && bus_addr == A_CMD && bus_wdata[0] && !keep_q[n]) |=> (esel_q[n] == '0));
  end
endmodule

// File: tb/tb_pinroute_xbar.sv
module tb_pinroute_xbar;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic [N-1:0] per_out = '0, per_oe = '0, per_in;
  logic         irq;

  pinroute_xbar #(.NUM_GPIO(N), .NUM_PER_OUT(N), .NUM_PER_IN(N)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .per_out(per_out), .per_oe(per_oe),
    .per_in(per_in), .irq(irq)
  );

  always #4 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct { string req; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];

  // Reference model state, built from the requirements
  int osel_m [N];
  int esel_m [N];
  int mode_m [N];
  int isel_m [N];
  int grp_m;

  task automatic push_exp(input string req, input logic [31:0] exp);
    exp_t e;
    e.req = req;
    e.exp = exp;
    sb_q.push_back(e);
  endtask

  task automatic monitor_cmp(input logic [31:0] act);
    exp_t e;
    e = sb_q.pop_front();
    checks++;
    if (act !== e.exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", e.req, act, e.exp);
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    push_exp(req, exp);
    monitor_cmp(act);
  endtask

  function automatic logic pick(int code, logic [N-1:0] v);
    if (code == 0) return 1'b0;
    if (code == 1) return 1'b1;
    if (code - 2 < N) return v[code-2];
    return 1'b0;
  endfunction

  function automatic logic [N-1:0] gin_m(logic [N-1:0] pads);
    logic [N-1:0] r = '0;
    if (grp_m != 0) for (int n = 0; n < N; n++) r[n] = pads[(n - grp_m + N) % N];
    return r;
  endfunction

  function automatic logic [N-1:0] pout_m(bit oe);
    logic [N-1:0] g, r;
    for (int n = 0; n < N; n++) g[n] = oe ? pick(esel_m[n], per_oe) : pick(osel_m[n], per_out);
    if (grp_m == 0) return oe ? per_oe : per_out;
    for (int p = 0; p < N; p++) r[p] = g[(p + grp_m) % N];
    return r;
  endfunction

  function automatic logic [N-1:0] pin_m();
    logic [N-1:0] r, gi;
    gi = gin_m(pad_in);
    for (int k = 0; k < N; k++) r[k] = pick(isel_m[k], gi);
    return r;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cfg_line(input int n, input int o, input int e, input int m);
    osel_m[n] = o; esel_m[n] = e; mode_m[n] = m;
    wr(8'h40 + 8'(n), 32'(o) | (32'(e) << 8) | (32'(m) << 16));
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int n = 0; n < N; n++) begin
      osel_m[n] = (n == 0) ? 2 : 0; esel_m[n] = osel_m[n]; mode_m[n] = 0;
      isel_m[n] = (n < 4) ? n + 3 : 0;
    end
    grp_m = 0;
    per_out = 8'hA5; per_oe = 8'h3C; pad_in = 8'hFF;
    wait_cyc(3);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(4);

    // Reset state
    rd(8'h00, d); check("R2 reset group", d, 0);
    check("R2 group0 pad_out", 32'(pad_out), 32'h A5);
    check("R2 group0 pad_oe", 32'(pad_oe), 32'h3C);
    rd(8'h04, d); check("R2 group0 gpio inputs isolated", d, 0);
    check("R7 default per_in", 32'(per_in), 32'(pin_m()));
    rd(8'h40, d); check("R7 line0 default", d, 32'h202);
    rd(8'h41, d); check("R7 line1 default", d, 0);
    rd(8'h80, d); check("R7 per_in0 default", d, 3);
    rd(8'h83, d); check("R7 per_in3 default", d, 6);

    // Group register
    wr(8'h00, 7); rd(8'h00, d); check("R1 write 7 ignored", d, 0);
    wr(8'h00, 6); rd(8'h00, d); check("R1 write 6 accepted", d, 6);
    wr(8'h00, 3); grp_m = 3;
    wait_cyc(4);
    rd(8'h04, d); check("R8 readback all high", d, 32'(gin_m(pad_in)));

    // Synchroniser timing
    @(negedge clk) pad_in = 8'h96;
    #1 check("R5 per_in combinational", 32'(per_in), 32'(pin_m()));
    @(negedge clk); #1 check("R8 one edge: old value", bus_rdata, 32'hFF);
    @(negedge clk); #1 check("R8 two edges: new value", bus_rdata, 32'(gin_m(8'h96)));
    check("R3 rotated input mapping", bus_rdata, 32'h B4);

    // Output crossbar
    cfg_line(1, 1, 1, 0); cfg_line(2, 7, 9, 0); cfg_line(3, 12, 1, 0);
    cfg_line(4, 9, 15, 0); cfg_line(5, 0, 1, 0); cfg_line(6, 3, 4, 0);
    cfg_line(7, 1, 0, 0);
    #1;
    check("R3 R4 R6 pad_out group3", 32'(pad_out), 32'(pout_m(0)));
    check("R3 R4 R6 pad_oe group3", 32'(pad_oe), 32'(pout_m(1)));
    @(negedge clk) per_out = 8'h5A;
    #1 check("R4 live per_out routing", 32'(pad_out), 32'(pout_m(0)));

    // Peripheral input crossbar
    isel_m = '{1, 15, 9, 2, 0, 5, 11, 6};
    for (int k = 0; k < N; k++) wr(8'h80 + 8'(k), 32'(isel_m[k]));
    #1 check("R5 R6 per_in selectors", 32'(per_in), 32'(pin_m()));

    // Routing reset command
    wr(8'h20, 32'h05);
    wr(8'h01, 1);
    for (int n = 0; n < N; n++) if (n != 0 && n != 2) esel_m[n] = 0;
    #1 check("R11 enables cleared except kept", 32'(pad_oe), 32'(pout_m(1)));
    check("R11 outputs untouched", 32'(pad_out), 32'(pout_m(0)));
    rd(8'h43, d); check("R11 line3 register", d, 32'h00C);

    // Interrupts: group 1, line 2 fed by pad 1
    wr(8'h00, 1); grp_m = 1;
    @(negedge clk) pad_in = 8'h00;
    wr(8'h10, 32'h04);
    wait_cyc(4);
    wr(8'h18, 32'hFF);
    rd(8'h18, d); check("R9 cleared start", d & 4, 0);
    @(negedge clk) pad_in = 8'h02;
    wait_cyc(4);
    rd(8'h18, d); check("R9 rising pending", d & 4, 4);
    check("R10 irq raised", 32'(irq), 1);
    wr(8'h18, 32'h04);
    rd(8'h18, d); check("R9 write-one clear", d & 4, 0);
    check("R10 irq dropped", 32'(irq), 0);

    cfg_line(2, osel_m[2], esel_m[2], 1);
    wr(8'h18, 32'h04);
    @(negedge clk) pad_in = 8'h00;
    wait_cyc(4);
    rd(8'h18, d); check("R9 falling pending", d & 4, 4);

    cfg_line(2, osel_m[2], esel_m[2], 2);
    wait_cyc(2);
    wr(8'h18, 32'h04);
    rd(8'h18, d); check("R9 high mode quiet while low", d & 4, 0);
    @(negedge clk) pad_in = 8'h02;
    wait_cyc(4);
    rd(8'h18, d); check("R9 high level pending", d & 4, 4);
    wr(8'h18, 32'h04);
    rd(8'h18, d); check("R9 level survives clear", d & 4, 4);

    cfg_line(2, osel_m[2], esel_m[2], 3);
    @(negedge clk) pad_in = 8'h00;
    wait_cyc(4);
    wr(8'h18, 32'h04);
    rd(8'h18, d); check("R9 low level pending", d & 4, 4);
    wr(8'h10, 0);
    #1 check("R10 masked irq", 32'(irq), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule